// File: doc/BRIEF.md
# Slave address match and acknowledge decider

This block sits beside the shift register of a two-wire serial controller and decides, for every byte that arrives, whether the device pulls the data line low in the ninth clock. A byte reaches the block as a one-cycle valid strobe together with a tag. The tag says whether the byte is the first byte after a START (an address byte) or a data byte. For an address byte, the upper seven bits are compared against the device's own address held in a configuration byte. They are also compared against the all-zero general-call code, which is recognised only when the configuration allows it. Bit 0 of the address byte, the read/write bit, is latched on a hit so that the surrounding controller can choose between slave transmit and slave receive.

An acknowledge-enable input gates every positive answer. When it is low, the device neither matches nor acknowledges anything. It drops off the bus but keeps its configured address, and it answers again as soon as the input returns high. When the controller acts as a master, the own-address configuration has no effect. An end-of-transfer strobe (a STOP, or a repeated START) releases the addressed state. All outputs are registered, so the decision is stable one clock after the byte strobe and stays valid well before the ninth bit period begins.

Top module: `slv_ack_decider`

## Requirements
- R1: After reset, sda_lvl_o is 1 and own_hit_o, gc_hit_o, evt_o, addressed_o and rw_o are all 0.
- R2: An address byte whose bits 7..1 equal addr_cfg_i[7:1] (non-zero), with ack_en_i=1 and a non-master role, makes the next cycle show own_hit_o=1, sda_lvl_o=0, addressed_o=1, rw_o equal to byte bit 0, and a single-cycle evt_o pulse.
- R3: An address byte with bits 7..1 all zero is a general call. It gives gc_hit_o=1, an acknowledge, addressed_o=1 and an evt_o pulse only when addr_cfg_i[0]=1. Otherwise it is not acknowledged. It never sets own_hit_o, even when the own address is zero.
- R4: With ack_en_i=0, every byte gives sda_lvl_o=1, no hit and no event. Raising ack_en_i again restores matching with the unchanged configuration.
- R5: In a master role (role_i 2'b01 transmitter or 2'b10 receiver), an address byte never produces a hit, whatever addr_cfg_i holds.
- R6: A data byte is acknowledged (sda_lvl_o=0) exactly when ack_en_i=1 and role_i is 2'b10 (master receiver) or 2'b11 (slave receiver). It leaves own_hit_o, gc_hit_o, addressed_o and rw_o unchanged and raises no event.
- R7: bus_stop_i clears addressed_o, own_hit_o and gc_hit_o, and releases sda_lvl_o to 1 on the next cycle. evt_o pulses in that cycle only if the device was addressed. A byte strobe in the same cycle is ignored.
- R8: An address byte matching neither own address nor an enabled general call gives sda_lvl_o=1, no event, and clears addressed_o. sda_lvl_o holds its value between byte strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_cfg_i | input | 8 | Bits 7..1 own address, bit 0 general-call enable |
| ack_en_i | input | 1 | Acknowledge enable |
| role_i | input | 2 | 00 other/slave transmit, 01 master transmit, 10 master receive, 11 slave receive |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is present |
| rx_is_addr_i | input | 1 | 1 when the strobed byte is an address byte |
| rx_byte_i | input | 8 | Received byte |
| bus_stop_i | input | 1 | STOP or repeated START observed |
| sda_lvl_o | output | 1 | Level for the ninth bit: 0 acknowledge, 1 released |
| own_hit_o | output | 1 | Last address byte matched the own address |
| gc_hit_o | output | 1 | Last address byte was an accepted general call |
| evt_o | output | 1 | One-cycle event on a hit or on the end of an addressed transfer |
| addressed_o | output | 1 | Device is currently addressed as a slave |
| rw_o | output | 1 | Read/write bit of the last matched address |

## Verification
The hardest situation to reach from the ports is a collision between an end-of-transfer strobe and a byte strobe in the same cycle. The bench drives both in a single call, while the device is addressed, and expects the byte to leave no trace. A second awkward corner is the own address configured as zero with general call disabled. Both are placed between ordinary transactions so that the held-state outputs show whether anything leaked. A sweep of address bytes across one configuration then covers the comparison broadly, and the end-of-transfer strobes between the sweep steps keep each step independent.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    ROLE_OTHER = 2'b00,
    ROLE_MTX   = 2'b01,
    ROLE_MRX   = 2'b10,
    ROLE_SRX   = 2'b11
  } role_e;

  // the controller currently drives the clock
  function automatic logic role_is_master(input logic [1:0] r);
    return (r == ROLE_MTX) || (r == ROLE_MRX);
  endfunction

  // the controller is the receiving side of data bytes
  function automatic logic role_takes_data(input logic [1:0] r);
    return (r == ROLE_MRX) || (r == ROLE_SRX);
  endfunction

endpackage

// File: rtl/sad_addr_cmp.sv
module sad_addr_cmp #(
  parameter int AW = 7
) (
  input  logic [AW:0] rx_byte,
  input  logic [AW:0] cfg,
  input  logic        ack_en,
  input  logic [1:0]  role,
  output logic        own_hit,
  output logic        gc_hit
);
  import sad_pkg::*;

  localparam logic [AW-1:0] GC_CODE = '0;

  logic [AW-1:0] rx_addr;
  logic [AW-1:0] own_addr;
  logic          gc_allowed;
  logic          may_answer;
  logic          is_gc_code;

  always_comb begin
    rx_addr    = rx_byte[AW:1];
    own_addr   = cfg[AW:1];
    gc_allowed = cfg[0];
    may_answer = ack_en && !role_is_master(role);
    is_gc_code = (rx_addr == GC_CODE);
    own_hit    = may_answer && !is_gc_code && (rx_addr == own_addr);
    gc_hit     = may_answer && is_gc_code && gc_allowed;
  end

endmodule

// File: rtl/sad_ack_policy.sv
module sad_ack_policy (
  input  logic       is_addr,
  input  logic       own_hit,
  input  logic       gc_hit,
  input  logic       ack_en,
  input  logic [1:0] role,
  output logic       ack
);
  import sad_pkg::*;

  always_comb begin
    if (!ack_en)      ack = 1'b0;
    else if (is_addr) ack = own_hit || gc_hit;
    else              ack = role_takes_data(role);
  end

endmodule

// File: rtl/sad_state_reg.sv
module sad_state_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic is_addr,
  input  logic own_hit,
  input  logic gc_hit,
  input  logic ack,
  input  logic rw_bit,
  input  logic stop,
  output logic sda_lvl,
  output logic own_q,
  output logic gc_q,
  output logic evt_q,
  output logic addressed_q,
  output logic rw_q
);

  logic any_hit;
  assign any_hit = own_hit || gc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_lvl     <= 1'b1;
      own_q       <= 1'b0;
      gc_q        <= 1'b0;
      evt_q       <= 1'b0;
      addressed_q <= 1'b0;
      rw_q        <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (stop) begin
        sda_lvl     <= 1'b1;
        own_q       <= 1'b0;
        gc_q        <= 1'b0;
        addressed_q <= 1'b0;
        evt_q       <= addressed_q;
      end else if (take) begin
        sda_lvl <= !ack;
        if (is_addr) begin
          own_q       <= own_hit;
          gc_q        <= gc_hit;
          addressed_q <= any_hit;
          evt_q       <= any_hit;
          if (any_hit) rw_q <= rw_bit;
        end
      end
    end
  end

endmodule

// File: rtl/slv_ack_decider.sv
module slv_ack_decider #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW:0] addr_cfg_i,
  input  logic        ack_en_i,
  input  logic [1:0]  role_i,
  input  logic        rx_valid_i,
  input  logic        rx_is_addr_i,
  input  logic [AW:0] rx_byte_i,
  input  logic        bus_stop_i,
  output logic        sda_lvl_o,
  output logic        own_hit_o,
  output logic        gc_hit_o,
  output logic        evt_o,
  output logic        addressed_o,
  output logic        rw_o
);

  // named internal events, observed by the checker
  logic w_take;
  logic w_own;
  logic w_gc;
  logic w_ack;

  assign w_take = rx_valid_i && !bus_stop_i;

  sad_addr_cmp #(.AW(AW)) u_cmp (
    .rx_byte (rx_byte_i),
    .cfg     (addr_cfg_i),
    .ack_en  (ack_en_i),
    .role    (role_i),
    .own_hit (w_own),
    .gc_hit  (w_gc)
  );

  sad_ack_policy u_pol (
    .is_addr (rx_is_addr_i),
    .own_hit (w_own),
    .gc_hit  (w_gc),
    .ack_en  (ack_en_i),
    .role    (role_i),
    .ack     (w_ack)
  );

  sad_state_reg u_st (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (w_take),
    .is_addr     (rx_is_addr_i),
    .own_hit     (w_own),
    .gc_hit      (w_gc),
    .ack         (w_ack),
    .rw_bit      (rx_byte_i[0]),
    .stop        (bus_stop_i),
    .sda_lvl     (sda_lvl_o),
    .own_q       (own_hit_o),
    .gc_q        (gc_hit_o),
    .evt_q       (evt_o),
    .addressed_q (addressed_o),
    .rw_q        (rw_o)
  );

endmodule

// File: rtl/slv_ack_decider_chk.sv
module slv_ack_decider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_en_i,
  input logic [1:0] role_i,
  input logic       rx_valid_i,
  input logic       rx_is_addr_i,
  input logic       bus_stop_i,
  input logic       sda_lvl_o,
  input logic       own_hit_o,
  input logic       gc_hit_o,
  input logic       evt_o,
  input logic       addressed_o,
  input logic       w_take,
  input logic       w_ack
);

  a_r4_no_ack_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i && !bus_stop_i && !ack_en_i |=> sda_lvl_o);

  a_r5_master_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i && rx_is_addr_i && !bus_stop_i && (role_i == 2'b01 || role_i == 2'b10)
      |=> !own_hit_o && !gc_hit_o);

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop_i |=> !addressed_o && sda_lvl_o && !own_hit_o && !gc_hit_o);

  a_r7_stop_event: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop_i && addressed_o |=> evt_o);

  a_r2_event_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(rx_valid_i || bus_stop_i));

  a_r3_hits_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(own_hit_o && gc_hit_o));

  a_r6_data_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i && !rx_is_addr_i && !bus_stop_i |=> $stable(addressed_o) && !evt_o);

  a_r2_level_follows_decision: assert property (@(posedge clk) disable iff (!rst_n)
    w_take |=> (sda_lvl_o == !$past(w_ack)));

  a_r8_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i && !bus_stop_i |=> $stable(sda_lvl_o));

endmodule

bind slv_ack_decider slv_ack_decider_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack_en_i     (ack_en_i),
  .role_i       (role_i),
  .rx_valid_i   (rx_valid_i),
  .rx_is_addr_i (rx_is_addr_i),
  .bus_stop_i   (bus_stop_i),
  .sda_lvl_o    (sda_lvl_o),
  .own_hit_o    (own_hit_o),
  .gc_hit_o     (gc_hit_o),
  .evt_o        (evt_o),
  .addressed_o  (addressed_o),
  .w_take       (w_take),
  .w_ack        (w_ack)
);

// File: tb/slv_ack_decider_tb.sv
module slv_ack_decider_tb;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_cfg_i = 8'h00;
  logic       ack_en_i = 1'b0;
  logic [1:0] role_i = 2'b00;
  logic       rx_valid_i = 1'b0;
  logic       rx_is_addr_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       bus_stop_i = 1'b0;
  logic sda_lvl_o, own_hit_o, gc_hit_o, evt_o, addressed_o, rw_o;

  always #(PERIOD/2) clk = ~clk;

  slv_ack_decider u_dut (
    .clk(clk), .rst_n(rst_n), .addr_cfg_i(addr_cfg_i), .ack_en_i(ack_en_i),
    .role_i(role_i), .rx_valid_i(rx_valid_i), .rx_is_addr_i(rx_is_addr_i),
    .rx_byte_i(rx_byte_i), .bus_stop_i(bus_stop_i), .sda_lvl_o(sda_lvl_o),
    .own_hit_o(own_hit_o), .gc_hit_o(gc_hit_o), .evt_o(evt_o),
    .addressed_o(addressed_o), .rw_o(rw_o)
  );

  typedef struct {
    logic [5:0] v;   // {sda, own, gc, evt, addressed, rw}
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 0;

  // stimulus settings picked up by the driver
  logic [7:0] t_cfg = 8'h00;
  logic       t_en = 1'b0;
  logic [1:0] t_role = 2'b00;

  // reference state, kept from the requirements
  logic m_sda = 1'b1, m_own = 1'b0, m_gc = 1'b0, m_adr = 1'b0, m_rw = 1'b0;

  task automatic drive(input logic v, input logic a, input logic [7:0] b,
                       input logic s, input string tag);
    exp_t e;
    logic mst, hit_o, hit_g, ev;
    @(negedge clk);
    addr_cfg_i = t_cfg; ack_en_i = t_en; role_i = t_role;
    rx_valid_i = v; rx_is_addr_i = a; rx_byte_i = b; bus_stop_i = s;
    mst = (t_role == 2'b01) || (t_role == 2'b10);
    ev = 1'b0;
    if (s) begin
      ev = m_adr;
      m_sda = 1'b1; m_own = 1'b0; m_gc = 1'b0; m_adr = 1'b0;
    end else if (v && a) begin
      hit_o = t_en && !mst && (b[7:1] != 7'd0) && (b[7:1] == t_cfg[7:1]);
      hit_g = t_en && !mst && (b[7:1] == 7'd0) && t_cfg[0];
      m_own = hit_o; m_gc = hit_g; m_adr = hit_o | hit_g; ev = hit_o | hit_g;
      m_sda = !(hit_o | hit_g);
      if (hit_o | hit_g) m_rw = b[0];
    end else if (v) begin
      m_sda = !(t_en && (t_role == 2'b10 || t_role == 2'b11));
    end
    e.v = {m_sda, m_own, m_gc, ev, m_adr, m_rw};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 8'h00, 1'b0, tag);
  endtask

  // monitor: one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        logic [5:0] act;
        e = q.pop_front();
        act = {sda_lvl_o, own_hit_o, gc_hit_o, evt_o, addressed_o, rw_o};
        n_chk++;
        if (act !== e.v) begin
          n_err++;
          $display("FAIL %s: {sda,own,gc,evt,adr,rw} actual=%b expected=%b", e.tag, act, e.v);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if ({sda_lvl_o, own_hit_o, gc_hit_o, evt_o, addressed_o, rw_o} !== 6'b100000) begin
      n_err++;
      $display("FAIL R1 reset: actual=%b expected=100000",
               {sda_lvl_o, own_hit_o, gc_hit_o, evt_o, addressed_o, rw_o});
    end
    @(negedge clk);
    rst_n = 1'b1;

    t_cfg = 8'h54; t_en = 1'b1; t_role = 2'b00;
    idle("R1 idle after reset");
    drive(1, 1, 8'h55, 0, "R2 own address read");
    idle("R2 event is one cycle, state held");
    t_role = 2'b11;
    drive(1, 0, 8'hA5, 0, "R6 data ack in slave receive");
    t_role = 2'b00;
    drive(1, 0, 8'h3C, 0, "R6 data nack in other role");
    drive(0, 0, 8'h00, 1, "R7 stop while addressed");
    drive(0, 0, 8'h00, 1, "R7 stop while idle");
    drive(1, 1, 8'h00, 0, "R3 general call disabled");
    t_cfg = 8'h55;
    drive(1, 1, 8'h00, 0, "R3 general call enabled");
    drive(1, 1, 8'h54, 1, "R7 byte with stop ignored");
    idle("R8 level held");
    t_en = 1'b0;
    drive(1, 1, 8'h54, 0, "R4 disabled own address");
    t_role = 2'b10;
    drive(1, 0, 8'h11, 0, "R4 disabled data in master receive");
    t_en = 1'b1; t_role = 2'b00;
    drive(1, 1, 8'h54, 0, "R4 resume own address write");
    drive(0, 0, 8'h00, 1, "R7 stop ends transfer");
    t_role = 2'b10;
    drive(1, 1, 8'h54, 0, "R5 master receive ignores own address");
    drive(1, 1, 8'h00, 0, "R5 master receive ignores general call");
    drive(1, 0, 8'h77, 0, "R6 data ack in master receive");
    t_role = 2'b01;
    drive(1, 1, 8'h55, 0, "R5 master transmit ignores own address");
    drive(1, 0, 8'h77, 0, "R6 data nack in master transmit");
    t_role = 2'b00;
    drive(1, 1, 8'h55, 0, "R2 hit before mismatch");
    drive(1, 1, 8'h56, 0, "R8 mismatch clears addressed");
    t_cfg = 8'h00;
    drive(1, 1, 8'h00, 0, "R3 zero own address with call off");
    t_cfg = 8'h6E;
    for (int i = 0; i < 24; i++) begin
      drive(1, 1, 8'(i * 11 + 40), 0, "R8 address sweep");
      drive(0, 0, 8'h00, 1, "R7 sweep stop");
    end
    idle("drain");
    idle("drain");
    @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule